// File: doc/BRIEF.md
# EDID Serving Display I2C Register Block

This block presents four 32-bit registers on a simple single-cycle read/write bus and behaves, from software's point of view, like the I2C controller a graphics driver uses to fetch a monitor's EDID. It never toggles real clock or data lines. Each EDID byte comes from a local ROM that is filled through a load port. The register set is pin select, command, status and data. Two per-port inputs tell the block whether a display is attached and whether that display is a DisplayPort sink. Only a non-DisplayPort sink with a display attached gets its EDID served.

Software picks a port, writes a command that names the target, the start index, the byte count and the cycle type, and then reads the data register. Each read returns up to four bytes, packed low byte first. The block keeps a bus phase (idle, data or wait) and a read pointer. When the byte count is used up, it ends the transfer in the idle phase or the wait phase, depending on the cycle type. Read data is combinational from the current address during the read cycle. Side effects of a read or a write take place at the following rising clock edge.

Top module: `edid_i2c_regs`

## Requirements
- R1: After reset, the status register reads 0x01 (hardware-ready only), and the pin-select, command and data registers read 0.
- R2: The status register fields are bit 0 hardware-ready, bit 1 no-acknowledge, bit 2 active, bit 3 wait, bit 5 in-use, and bits 7:6 phase (0 idle, 1 data, 2 wait). Any pin-select write clears the pointer, the byte count, the cycle type and the mode, target and EDID flags. A pin value from 1 to NPORT selects port (pin-1) and then sets the phase to idle, clears active, and sets hardware-ready and wait. No-acknowledge is cleared and EDID marked available only when the port has a display present that is not DisplayPort; otherwise no-acknowledge is set. A pin value of 0 or above NPORT leaves the status unchanged.
- R3: Command fields are bit 0 read direction, bits 7:1 target address, bits 15:8 index, bits 24:16 byte count and bits 27:25 cycle type. Only target 0x50 marks the target selected. Any other address does not.
- R4: Cycle-type bit 26 (the index flag) loads the read pointer from the index field.
- R5: Cycle types 1, 3, 5 and 7 set the phase to data and set active. Type 4 (stop) acts only when the stored type is not 0. It then clears the transfer state, sets the phase to idle and clears active. Types 0, 2 and 6 leave the phase unchanged.
- R6: Bit 30 (software-ready) is always stored as 0 in the command register.
- R7: With bit 31 (clear-interrupt) stored, a command write with bit 31 set is ignored. A write with bit 31 clear clears only that stored bit, sets the status to hardware-ready only (plus no-acknowledge if no EDID is available) and sets the phase to idle. A command write that newly sets bit 31 sets hardware-ready.
- R8: A data read with read direction set and remaining = count − pointer > 0 replaces the low min(4, remaining) bytes of the data register with fetched bytes, byte i in bits 8i+7:8i. The other bytes keep their old value. The pointer advances by the number of bytes actually fetched.
- R9: When such a read has remaining ≤ 4, the phase becomes idle for types 5 and 7 and wait for every other type, and the transfer state is cleared. A data read with remaining ≤ 0 returns the stored value unchanged.
- R10: A status read returns the current value and then sets in-use. Writing 1 to bit 5 clears in-use, and no other status bit is writable. Writes to the data register are ignored.
- R11: A fetched byte is 0 and does not advance the pointer when no port mode is set, no target is selected, no EDID is available, the selected display is absent or the pointer is at or past 128.
- R12: A data read with read direction clear returns the stored value and changes neither the data register nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 pin, 1 command, 2 status, 3 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| disp_present | input | NPORT | Display attached, per port |
| disp_is_dp | input | NPORT | Attached display is DisplayPort, per port |
| rom_load | input | 1 | EDID ROM write strobe |
| rom_addr | input | log2(ROM_BYTES) | EDID ROM write address |
| rom_data | input | 8 | EDID ROM write byte |

## Verification
Two conditions are hard to reach from the ports. The first is a fetch that crosses the ROM end inside one data read. The bench reaches it with an indexed command at 126 and a byte count far beyond the ROM, so one read gets two real bytes and two zero bytes, and the next read shows that the pointer is stuck. The second is a stop command that must be ignored because the stored type is "no cycle". The bench first writes a no-cycle command and then a stop. A following read that still returns bytes from the live pointer shows the stop had no effect. A repeated stop then shows the effective case.

// File: rtl/edid_regs_pkg.sv
package edid_regs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;

   localparam logic [1:0] RA_PIN  = 2'd0;
   localparam logic [1:0] RA_CMD  = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_DATA = 2'd3;

   localparam logic [2:0] CY_NONE  = 3'd0;
   localparam logic [2:0] CY_WAIT  = 3'd1;
   localparam logic [2:0] CY_IDXW  = 3'd3;
   localparam logic [2:0] CY_STOP  = 3'd4;
   localparam logic [2:0] CY_STOPD = 3'd5;
   localparam logic [2:0] CY_IDXS  = 3'd7;

   localparam int CMD_RD    = 0;
   localparam int CMD_IDXF  = 26;
   localparam int CMD_SWRDY = 30;
   localparam int CMD_CLRI  = 31;

endpackage

// File: rtl/edid_rom.sv
module edid_rom #(
   parameter int BYTES = 128,
   parameter int LANES = 4,
   localparam int AW = $clog2(BYTES)
) (
   input  logic                 clk,
   input  logic                 load_en,
   input  logic [AW-1:0]        load_addr,
   input  logic [7:0]           load_data,
   input  logic [7:0]           rd_base,
   output logic [LANES-1:0][7:0] lane_data,
   output logic [LANES-1:0]     lane_ok
);

   localparam logic [9:0] LIM = 10'(BYTES);

   if (BYTES < 4 || BYTES > 256) begin : g_bad_bytes
      $error("edid_rom: BYTES must lie in 4..256");
   end

   logic [7:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (load_en) mem[load_addr] <= load_data;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [8:0] at;
      assign at           = {1'b0, rd_base} + 9'(i);
      assign lane_ok[i]   = {1'b0, at} < LIM;
      assign lane_data[i] = lane_ok[i] ? mem[at[AW-1:0]] : 8'h00;
   end

endmodule

// File: rtl/edid_pack.sv
module edid_pack #(
   parameter int LANES = 4,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic                   base_ok,
   input  logic [LANES-1:0]       lane_ok,
   input  logic [LANES-1:0][7:0]  lane_data,
   input  logic signed [9:0]      remain,
   input  logic [8*LANES-1:0]     old_word,
   output logic [8*LANES-1:0]     new_word,
   output logic [CW-1:0]          adv,
   output logic                   has_data,
   output logic                   last
);

   logic [LANES-1:0] take;

   for (genvar i = 0; i < LANES; i++) begin : g_byte
      logic in_win;
      assign in_win  = remain > $signed(10'(i));
      assign take[i] = base_ok & lane_ok[i] & in_win;
      assign new_word[8*i +: 8] = !in_win ? old_word[8*i +: 8] :
                                  (take[i] ? lane_data[i] : 8'h00);
   end

   always_comb begin
      adv = '0;
      for (int k = 0; k < LANES; k++) adv = adv + CW'(take[k]);
   end

   assign has_data = remain > 10'sd0;
   assign last     = remain <= $signed(10'(LANES));

endmodule

// File: rtl/edid_i2c_regs.sv
module edid_i2c_regs
   import edid_regs_pkg::*;
#(
   parameter int         NPORT     = 4,
   parameter int         ROM_BYTES = 128,
   parameter int         LANES     = 4,
   parameter logic [6:0] TGT_ADDR  = 7'h50
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [1:0]                   bus_addr,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   input  logic [NPORT-1:0]             disp_present,
   input  logic [NPORT-1:0]             disp_is_dp,
   input  logic                         rom_load,
   input  logic [$clog2(ROM_BYTES)-1:0] rom_addr,
   input  logic [7:0]                   rom_data
);

   localparam int         PW  = (NPORT > 1) ? $clog2(NPORT) : 1;
   localparam int         CW  = $clog2(LANES + 1);
   localparam logic [2:0] NP3 = 3'(NPORT);

   if (NPORT < 1 || NPORT > 7) begin : g_bad_nport
      $error("edid_i2c_regs: NPORT must lie in 1..7");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("edid_i2c_regs: LANES must lie in 1..4");
   end

   // register state
   logic [2:0]    pin_q;
   logic [31:0]   cmd_q, data_q;
   logic          st_hw, st_nak, st_act, st_wait, st_inuse;
   phase_e        phase_q;
   // transfer state
   logic          mode_q, tgt_q, avail_q;
   logic [7:0]    ptr_q;
   logic [8:0]    cnt_q;
   logic [2:0]    cyc_q;
   logic [PW-1:0] port_q;

   // decode
   logic wr_pin, wr_cmd, wr_st, wr_dat, rd_st, rd_dat;
   assign wr_pin = bus_wr && bus_addr == RA_PIN;
   assign wr_cmd = bus_wr && bus_addr == RA_CMD;
   assign wr_st  = bus_wr && bus_addr == RA_STAT;
   assign wr_dat = bus_wr && bus_addr == RA_DATA;
   assign rd_st  = bus_rd && !bus_wr && bus_addr == RA_STAT;
   assign rd_dat = bus_rd && !bus_wr && bus_addr == RA_DATA;

   logic [2:0]    pin_w;
   logic          pin_ok, sink_ok;
   logic [PW-1:0] pidx;
   assign pin_w   = bus_wdata[2:0];
   assign pin_ok  = pin_w != 3'd0 && pin_w <= NP3;
   assign pidx    = PW'(pin_w - 3'd1);
   assign sink_ok = disp_present[pidx] && !disp_is_dp[pidx];

   logic [31:0] cmd_w;
   assign cmd_w = bus_wdata & ~(32'd1 << CMD_SWRDY);

   logic stop_eff;
   assign stop_eff = wr_cmd && !cmd_q[CMD_CLRI] && cmd_w[27:25] == CY_STOP &&
                     cmd_q[27:25] != CY_NONE;

   // fetch datapath
   logic signed [9:0]      remain;
   logic                   fetch_ok, has_data, last, rd_live, kill;
   logic [LANES-1:0][7:0]  lane_data;
   logic [LANES-1:0]       lane_ok;
   logic [8*LANES-1:0]     new_word;
   logic [CW-1:0]          adv;
   logic [31:0]            merged;

   assign remain   = $signed({1'b0, cnt_q} - {2'b00, ptr_q});
   assign fetch_ok = mode_q && tgt_q && avail_q && disp_present[port_q];

   edid_rom #(.BYTES(ROM_BYTES), .LANES(LANES)) u_rom (
      .clk       (clk),
      .load_en   (rom_load),
      .load_addr (rom_addr),
      .load_data (rom_data),
      .rd_base   (ptr_q),
      .lane_data (lane_data),
      .lane_ok   (lane_ok)
   );

   edid_pack #(.LANES(LANES)) u_pack (
      .base_ok   (fetch_ok),
      .lane_ok   (lane_ok),
      .lane_data (lane_data),
      .remain    (remain),
      .old_word  (data_q[8*LANES-1:0]),
      .new_word  (new_word),
      .adv       (adv),
      .has_data  (has_data),
      .last      (last)
   );

   if (LANES == 4) begin : g_full
      assign merged = new_word;
   end else begin : g_part
      assign merged = {data_q[31:8*LANES], new_word};
   end

   assign rd_live = rd_dat && cmd_q[CMD_RD] && has_data;
   assign kill    = stop_eff || (rd_live && last);

   // read mux
   always_comb begin
      case (bus_addr)
         RA_PIN:  bus_rdata = {29'd0, pin_q};
         RA_CMD:  bus_rdata = cmd_q;
         RA_STAT: bus_rdata = {24'd0, phase_q, st_inuse, 1'b0,
                               st_wait, st_act, st_nak, st_hw};
         default: bus_rdata = rd_live ? merged : data_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q    <= '0;
         cmd_q    <= '0;
         data_q   <= '0;
         st_hw    <= 1'b1;
         st_nak   <= 1'b0;
         st_act   <= 1'b0;
         st_wait  <= 1'b0;
         st_inuse <= 1'b0;
         phase_q  <= PH_IDLE;
         mode_q   <= 1'b0;
         tgt_q    <= 1'b0;
         avail_q  <= 1'b0;
         ptr_q    <= '0;
         cnt_q    <= '0;
         cyc_q    <= CY_NONE;
         port_q   <= '0;
      end else begin
         if (wr_pin) begin
            pin_q   <= pin_w;
            mode_q  <= 1'b0;
            tgt_q   <= 1'b0;
            avail_q <= 1'b0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            cyc_q   <= CY_NONE;
            if (pin_ok) begin
               mode_q  <= 1'b1;
               phase_q <= PH_IDLE;
               st_act  <= 1'b0;
               st_hw   <= 1'b1;
               st_wait <= 1'b1;
               if (sink_ok) begin
                  port_q  <= pidx;
                  avail_q <= 1'b1;
                  st_nak  <= 1'b0;
               end else begin
                  st_nak  <= 1'b1;
               end
            end
         end else if (wr_cmd) begin
            if (cmd_q[CMD_CLRI]) begin
               if (!bus_wdata[CMD_CLRI]) begin
                  cmd_q[CMD_CLRI] <= 1'b0;
                  st_hw    <= 1'b1;
                  st_nak   <= !avail_q;
                  st_act   <= 1'b0;
                  st_wait  <= 1'b0;
                  st_inuse <= 1'b0;
                  phase_q  <= PH_IDLE;
               end
            end else begin
               if (bus_wdata[CMD_CLRI]) st_hw <= 1'b1;
               cnt_q <= cmd_w[24:16];
               cyc_q <= cmd_w[27:25];
               if (cmd_w[7:1] == TGT_ADDR) tgt_q <= 1'b1;
               if (cmd_w[CMD_IDXF]) ptr_q <= cmd_w[15:8];
               case (cmd_w[27:25])
                  CY_STOP: begin
                     if (stop_eff) begin
                        phase_q <= PH_IDLE;
                        st_act  <= 1'b0;
                     end
                  end
                  CY_WAIT, CY_IDXW, CY_STOPD, CY_IDXS: begin
                     phase_q <= PH_DATA;
                     st_act  <= 1'b1;
                  end
                  default: ;
               endcase
               cmd_q <= cmd_w;
            end
         end else if (wr_st) begin
            if (bus_wdata[5]) st_inuse <= 1'b0;
         end else if (rd_st) begin
            st_inuse <= 1'b1;
         end else if (rd_live) begin
            data_q <= merged;
            ptr_q  <= ptr_q + 8'(adv);
            if (last) phase_q <= (cyc_q == CY_STOPD || cyc_q == CY_IDXS) ?
                                 PH_IDLE : PH_WAIT;
         end
         if (kill) begin
            mode_q  <= 1'b0;
            tgt_q   <= 1'b0;
            avail_q <= 1'b0;
            ptr_q   <= '0;
            cnt_q   <= '0;
            cyc_q   <= CY_NONE;
         end
      end
   end

   // assertions
   p_pin_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pin && pin_ok |=> st_hw && st_wait && !st_act && phase_q == PH_IDLE);

   p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_eff |=> !st_act && phase_q == PH_IDLE && !mode_q && ptr_q == 8'd0);

   p_data_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && !cmd_q[CMD_CLRI] && bus_wdata[25] |=> st_act && phase_q == PH_DATA);

   p_clr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && cmd_q[CMD_CLRI] && bus_wdata[CMD_CLRI] |=> $stable(cmd_q));

   p_adv_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_live && !last |=> ptr_q >= $past(ptr_q) &&
                           {1'b0, ptr_q} <= {1'b0, $past(ptr_q)} + 9'(LANES));

   p_inuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_st |=> st_inuse);

   p_data_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dat |=> $stable(data_q));

   p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_dat && cmd_q[CMD_RD] && !fetch_ok && !last |=> $stable(ptr_q));

endmodule

// File: tb/test_edid_i2c_regs.sv
module test_edid_i2c_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  disp_present = 4'b0110;
   logic [3:0]  disp_is_dp = 4'b0100;
   logic        rom_load = 1'b0;
   logic [6:0]  rom_addr = '0;
   logic [7:0]  rom_data = '0;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   edid_i2c_regs i_edid_i2c_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .disp_present(disp_present), .disp_is_dp(disp_is_dp),
      .rom_load(rom_load), .rom_addr(rom_addr), .rom_data(rom_data)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  a;
      logic [31:0] d;
      logic [31:0] x;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 2'd0, 32'h0000_0002, 32'h0,         8'd2},  // select port 1
      '{1'b0, 2'd2, 32'h0,         32'h0000_0009, 8'd2},  // R2 status
      '{1'b0, 2'd2, 32'h0,         32'h0000_0029, 8'd10}, // R10 in-use set
      '{1'b1, 2'd2, 32'h0000_0020, 32'h0,         8'd10},
      '{1'b0, 2'd2, 32'h0,         32'h0000_0009, 8'd10}, // R10 cleared
      '{1'b1, 2'd1, 32'h4E16_10A1, 32'h0,         8'd6},
      '{1'b0, 2'd1, 32'h0,         32'h0E16_10A1, 8'd6},  // R6 stripped
      '{1'b0, 2'd2, 32'h0,         32'h0000_006D, 8'd5},  // R5 data, active
      '{1'b0, 2'd3, 32'h0,         32'hB6B7_B4B5, 8'd8},  // R8 four bytes
      '{1'b0, 2'd3, 32'h0,         32'hB6B7_B0B1, 8'd8},  // R8 two bytes
      '{1'b0, 2'd2, 32'h0,         32'h0000_002D, 8'd9},  // R9 stop end idle
      '{1'b0, 2'd3, 32'h0,         32'hB6B7_B0B1, 8'd9}   // R9 nothing left
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic st_chk(input string tag, input logic [31:0] exp);
      wr(2'd2, 32'h20);
      rchk(tag, 2'd2, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rchk("R1 status", 2'd2, 32'h01);
      rchk("R1 cmd", 2'd1, 32'h0);
      rchk("R1 data", 2'd3, 32'h0);
      rchk("R1 pin", 2'd0, 32'h0);
      wr(2'd2, 32'h20);
      for (int k = 0; k < 128; k++) begin
         @(negedge clk);
         rom_load = 1'b1; rom_addr = 7'(k); rom_data = 8'(k) ^ 8'hA5;
      end
      @(negedge clk);
      rom_load = 1'b0;

      for (int n = 0; n < NV; n++) begin
         if (TBL[n].wr) wr(TBL[n].a, TBL[n].d);
         else rchk($sformatf("R%0d row %0d", TBL[n].rq, n), TBL[n].a, TBL[n].x);
      end

      // R2 DisplayPort sink gives no-acknowledge
      wr(2'd0, 32'd3);
      st_chk("R2 dp nak", 32'h0B);
      // R11 no EDID available: zero bytes; R9 wait ending for type 1
      wr(2'd1, 32'h0204_00A1);
      rchk("R11 unavailable", 2'd3, 32'h0);
      st_chk("R9 wait ending", 32'h8F);
      // R2 pin beyond port count
      wr(2'd0, 32'd5);
      st_chk("R2 bad pin", 32'h8F);

      // R3 foreign target ignored
      wr(2'd0, 32'd2);
      st_chk("R2 reselect", 32'h09);
      wr(2'd1, 32'h0608_00A3);
      rchk("R3 foreign target", 2'd3, 32'h0);
      wr(2'd1, 32'h0008_00A1);
      rchk("R3 target then R11 no advance", 2'd3, 32'hA6A7_A4A5);

      // R5 stop ignored after no-cycle, then effective
      wr(2'd1, 32'h0808_00A1);
      rchk("R5 stop ignored", 2'd3, 32'hA2A3_A0A1);
      st_chk("R9 stop type ends in wait", 32'h8D);
      wr(2'd1, 32'h0808_00A1);
      st_chk("R5 stop effective", 32'h09);
      rchk("R5 stop cleared count", 2'd3, 32'hA2A3_A0A1);

      // R4 index near end, R11 boundary
      wr(2'd0, 32'd2);
      wr(2'd1, 32'h06C8_7EA1);
      rchk("R4 index 126 R11 edge", 2'd3, 32'h0000_DADB);
      rchk("R11 past end", 2'd3, 32'h0);

      // R12 read direction clear
      wr(2'd1, 32'h0608_00A1);
      rchk("R4 index reload", 2'd3, 32'hA6A7_A4A5);
      wr(2'd1, 32'h0208_00A0);
      rchk("R12 no read dir", 2'd3, 32'hA6A7_A4A5);
      wr(2'd1, 32'h0008_00A1);
      rchk("R12 pointer kept", 2'd3, 32'hA2A3_A0A1);

      // R10 data write ignored
      wr(2'd3, 32'h1234_5678);
      rchk("R10 data write", 2'd3, 32'hA2A3_A0A1);

      // R11 display absent at fetch time
      wr(2'd0, 32'd2);
      wr(2'd1, 32'h0608_00A1);
      disp_present = 4'b0100;
      rchk("R11 display gone", 2'd3, 32'h0);
      disp_present = 4'b0110;
      rchk("R11 display back", 2'd3, 32'hA6A7_A4A5);

      // R7 clear-interrupt handling
      wr(2'd0, 32'd2);
      wr(2'd1, 32'h8000_00A1);
      wr(2'd1, 32'h8E16_10A1);
      rchk("R7 held write ignored", 2'd1, 32'h8000_00A1);
      wr(2'd1, 32'h0);
      rchk("R7 only bit cleared", 2'd1, 32'h0000_00A1);
      st_chk("R7 status ready", 32'h01);
      wr(2'd0, 32'd3);
      wr(2'd1, 32'h8000_0000);
      wr(2'd1, 32'h0);
      st_chk("R7 status nak", 32'h03);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

endmodule